// File: doc/BRIEF.md
# Page-Aware EEPROM Address Counter

This block keeps the current byte address of a serial EEPROM core. The address is the page-block select bits taken from the device-select byte, placed above the 8-bit word address. When the bus protocol controller has received the word address of a write-addressed transfer, it raises a load strobe. The counter then captures both fields. After each byte moves across the bus, the controller raises a step strobe, so that a later current-address read continues from the following location.

The step behaves in one of two ways, chosen by a mode input. In write mode only the low offset bits inside a 16-byte page count. After the last offset of a page the address returns to the start of the same page, and the page and block bits stay as they were. In read mode the whole address counts, with carries from the word byte into the block bits, and the count wraps to zero after the last byte of the array. The counter drives the full address and the in-page offset. The memory array and the bus state machine are outside this block.

Top module: `eeprom_addr_ctr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `addr_o` is 0.
- R2: A cycle with `load_i` high makes `addr_o` equal `{blk_i, word_i}` after the next rising clock edge, with `blk_i` in the upper 2 bits and `word_i` in the low 8 bits.
- R3: When `load_i` and `step_i` are both high in the same cycle, the load takes effect and the step is ignored.
- R4: A step with `mode_rd_i` = 0 (write mode) adds one to `addr_o[3:0]` only, going from 15 to 0, and leaves `addr_o[9:4]` unchanged.
- R5: A step with `mode_rd_i` = 1 (read mode) adds one to the full 10-bit address, so a carry passes out of the word byte into the block bits (for example 0x0FF becomes 0x100).
- R6: A read-mode step at address 0x3FF gives address 0x000.
- R7: A cycle with neither `load_i` nor `step_i` high leaves `addr_o` unchanged, whatever `mode_rd_i` is.
- R8: `offs_o` always equals `addr_o[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe: capture block and word fields |
| blk_i | input | 2 | Page-block select bits from the device-select byte |
| word_i | input | 8 | Word address byte |
| step_i | input | 1 | Advance strobe, one pulse per byte transferred |
| mode_rd_i | input | 1 | Wrap select: 1 = whole-array (read), 0 = in-page (write) |
| addr_o | output | 10 | Current address |
| offs_o | output | 4 | Offset within the current 16-byte page |

## Verification
The hardest states to reach are the two wrap boundaries. Offset 15 inside a page whose upper bits are not zero would show an in-page step that wrongly carries. Address 0x3FF shows the end-of-array rollover. Reaching either by stepping from reset would take hundreds of strobes. The stimulus therefore loads an address just below each boundary and steps across it. It also crosses the word-to-block carry at 0x0FF in read mode. A long pseudo-random run then mixes loads, steps in both modes, collisions and idle cycles. A behavioural model checks every clock of that run.

// File: rtl/eeprom_addr_ctr_pkg.sv
package eeprom_addr_ctr_pkg;
   // Wrap behaviour of one advance
   typedef enum logic {
      WRAP_PAGE = 1'b0,
      WRAP_FULL = 1'b1
   } wrap_sel_t;

   // Priority of simultaneous strobes
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_STEP = 2'd1,
      ACT_LOAD = 2'd2
   } ctr_act_t;
endpackage

// File: rtl/eeprom_addr_step.sv
module eeprom_addr_step
   import eeprom_addr_ctr_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  wrap_sel_t         sel_i,
   output logic [ADDR_W-1:0] nxt_o
);
   localparam int HI_W = ADDR_W - PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page
         $error("eeprom_addr_step: PAGE_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] full_inc;
   logic [ADDR_W-1:0] page_inc;
   logic [PAGE_W-1:0] low_inc;

   assign full_inc = cur_i + ADDR_W'(1);
   assign low_inc  = cur_i[PAGE_W-1:0] + PAGE_W'(1);

   generate
      if (HI_W > 0) begin : g_split
         assign page_inc = {cur_i[ADDR_W-1:PAGE_W], low_inc};
      end else begin : g_whole
         assign page_inc = full_inc;
      end
   endgenerate

   always_comb begin
      unique case (sel_i)
         WRAP_FULL: nxt_o = full_inc;
         default:   nxt_o = page_inc;
      endcase
   end
endmodule

// File: rtl/eeprom_addr_reg.sv
module eeprom_addr_reg
   import eeprom_addr_ctr_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] step_val_i,
   output logic [ADDR_W-1:0] q_o
);
   generate
      if (ADDR_W < 1) begin : g_bad_w
         $error("eeprom_addr_reg: ADDR_W must be positive");
      end
   endgenerate

   ctr_act_t act;

   always_comb begin
      if (load_i)      act = ACT_LOAD;
      else if (step_i) act = ACT_STEP;
      else             act = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
      end else begin
         unique case (act)
            ACT_LOAD: q_o <= load_val_i;
            ACT_STEP: q_o <= step_val_i;
            default:  q_o <= q_o;
         endcase
      end
   end

   // R1
   rst_zero_chk: assert property (@(posedge clk)
      !rst_n |=> q_o == '0);
endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr
   import eeprom_addr_ctr_pkg::*;
#(
   parameter int BLK_W  = 2,
   parameter int WORD_W = 8,
   parameter int PAGE_W = 4,
   localparam int ADDR_W = BLK_W + WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BLK_W-1:0]  blk_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              step_i,
   input  logic              mode_rd_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [PAGE_W-1:0] offs_o
);
   generate
      if (BLK_W < 1 || WORD_W < 1) begin : g_bad_fields
         $error("eeprom_addr_ctr: field widths must be positive");
      end
      if (PAGE_W > WORD_W) begin : g_bad_page
         $error("eeprom_addr_ctr: page must fit in the word byte");
      end
   endgenerate

   logic [ADDR_W-1:0] load_val;
   logic [ADDR_W-1:0] step_val;
   wrap_sel_t         wrap_sel;

   assign load_val = {blk_i, word_i};
   assign wrap_sel = mode_rd_i ? WRAP_FULL : WRAP_PAGE;

   eeprom_addr_step #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W)
   ) u_step (
      .cur_i (addr_o),
      .sel_i (wrap_sel),
      .nxt_o (step_val)
   );

   eeprom_addr_reg #(
      .ADDR_W (ADDR_W)
   ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (load_val),
      .step_i     (step_i),
      .step_val_i (step_val),
      .q_o        (addr_o)
   );

   assign offs_o = addr_o[PAGE_W-1:0];

   // R2 R3
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> addr_o == $past({blk_i, word_i}));

   // R4
   page_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !mode_rd_i) |=>
         addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));

   // R4
   page_offs_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !mode_rd_i) |=>
         offs_o == PAGE_W'($past(offs_o) + PAGE_W'(1)));

   // R5 R6
   full_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && mode_rd_i) |=>
         addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1)));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(addr_o));
endmodule

// File: tb/tb_eeprom_addr_ctr.sv
module tb_eeprom_addr_ctr;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [1:0]    blk_i = '0;
   logic [7:0]    word_i = '0;
   logic          step_i = 1'b0;
   logic          mode_rd_i = 1'b0;
   logic [AW-1:0] addr_o;
   logic [3:0]    offs_o;

   int n_run = 0;
   int n_fail = 0;
   int ref_addr = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   eeprom_addr_ctr dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .blk_i     (blk_i),
      .word_i    (word_i),
      .step_i    (step_i),
      .mode_rd_i (mode_rd_i),
      .addr_o    (addr_o),
      .offs_o    (offs_o)
   );

   // Behavioural reference model
   always @(posedge clk) begin
      if (!rst_n)            ref_addr <= 0;
      else if (load_i)       ref_addr <= blk_i * 256 + word_i;
      else if (step_i) begin
         if (mode_rd_i)      ref_addr <= (ref_addr + 1) % 1024;
         else                ref_addr <= (ref_addr / 16) * 16 + (ref_addr + 1) % 16;
      end
   end

   task automatic check(input string tag);
      n_run++;
      if (addr_o !== AW'(ref_addr) || offs_o !== 4'(ref_addr % 16)) begin
         n_fail++;
         $display("FAIL %s: addr=%h offs=%h expected addr=%h offs=%h",
                  tag, addr_o, offs_o, AW'(ref_addr), 4'(ref_addr % 16));
      end
   endtask

   // Drive one cycle of stimulus, then compare after the edge
   task automatic cyc(input bit ld, input int a, input bit st, input bit rd,
                      input string tag);
      load_i    = ld;
      blk_i     = 2'(a / 256);
      word_i    = 8'(a % 256);
      step_i    = st;
      mode_rd_i = rd;
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      @(negedge clk);
      check("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, "R1 after release");
      cyc(1, 'h123, 0, 0, "R2 load 0x123");
      cyc(1, 'h2A0, 0, 1, "R2 load 0x2A0");
      // write-mode page wrap, upper bits nonzero
      cyc(1, 'h1FD, 0, 0, "R2 load 0x1FD");
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, "R4 R8 page step");
      // full page loop returns to start
      cyc(1, 'h2B7, 0, 0, "R2 load 0x2B7");
      for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, "R4 full page loop");
      // read-mode carry into block bits
      cyc(1, 'h0FE, 0, 1, "R2 load 0x0FE");
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, "R5 carry step");
      cyc(1, 'h10F, 0, 1, "R2 load 0x10F");
      cyc(0, 0, 1, 1, "R5 step past page end");
      // end-of-array wrap
      cyc(1, 'h3FE, 0, 1, "R2 load 0x3FE");
      cyc(0, 0, 1, 1, "R6 to 0x3FF");
      cyc(0, 0, 1, 1, "R6 wrap to 0");
      cyc(0, 0, 1, 1, "R6 after wrap");
      // idle with mode toggling
      cyc(0, 'h3AA, 0, 1, "R7 idle rd");
      cyc(0, 'h155, 0, 0, "R7 idle wr");
      cyc(0, 0, 0, 1, "R7 idle rd again");
      // collision
      cyc(1, 'h08F, 1, 0, "R3 load with write step");
      cyc(1, 'h3FF, 1, 1, "R3 load with read step");
      // pseudo-random mix
      begin
         logic [15:0] lf = 16'hACE1;
         for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0] & lf[1] & lf[2], int'(lf[15:6]), lf[3] | lf[4], lf[5],
                "R4 R5 R7 mixed");
         end
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #80000;
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: expired, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule